// File: doc/BRIEF.md
# Ethernet Datapath Reset Sequencer

This block drives the reset of the transmit and receive datapaths of a 10G Ethernet MAC. A reset request for a path does not pulse the reset directly. The block first sets the path's disable output, then waits for the path's busy flag to drop, with a drain timeout as a fallback. It then holds the path reset for a minimum number of cycles and releases it only while the clocks are reported stable. It then waits a settle time of about 500 ns, issues one statistics-clear pulse, clears the disable output and pulses done.

Each path has its own sequencer. A level-sensitive request for the register-block reset also drives both datapath resets, so the register block always leaves reset no later than either datapath. If a register-block reset overlaps a path's settle phase, the settle count starts again after the path's reset output really drops.

Top module: `mac_path_rst_seq`

## Requirements
- R1: While `regblk_reset_o` is high, `tx_reset_o` and `rx_reset_o` are both high.
- R2: Each of the three reset outputs, once raised, stays high for at least MIN_RST_CYC consecutive cycles (default 3).
- R3: Neither `tx_reset_o` nor `rx_reset_o` falls while `regblk_reset_o` is still high.
- R4: A request sampled while the path is idle raises that path's disable output in the next cycle. The disable output stays high for as long as the path sequencer holds its reset.
- R5: The path reset rises in the cycle after the busy input is sampled low. Busy is sampled from the second cycle after the request onward, so the reset rises at the earliest three cycles after the request is sampled.
- R6: If busy is still high after DRAIN_TIMEOUT drain cycles (default 32), the path goes on to reset anyway and its timeout output is set. The timeout output stays set until `rst`.
- R7: A reset output falls only at a clock edge where `clk_stable_i` was high. While `clk_stable_i` is low, the reset stays high beyond its minimum width.
- R8: The statistics-clear pulse comes SETTLE_CYC = ceil(SETTLE_NS*1000 / CLK_PERIOD_PS) cycles after the path's reset output falls (79 cycles at the defaults of 500 ns and 6400 ps). A register-block reset that overlaps the settle phase restarts this count.
- R9: Statistics-clear is high for exactly one cycle per sequence. Done is high for exactly the following cycle, and in that cycle the disable output is low.
- R10: A path's requests are ignored while its sequence is running, up to and including the done cycle. After done, disable stays low unless a new request arrives.
- R11: The transmit and receive sequencers run independently. Two requests in the same cycle give two identical, overlapping sequences.
- R12: In the cycle after `rst`, every output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| regblk_req_i | input | 1 | Level request for the register-block reset |
| tx_req_i | input | 1 | Transmit datapath reset request (software reset-control bit 0) |
| rx_req_i | input | 1 | Receive datapath reset request (software reset-control bit 8) |
| tx_busy_i | input | 1 | Transmit transfer-in-progress flag (status bit 8) |
| rx_busy_i | input | 1 | Receive transfer-in-progress flag (status bit 8) |
| clk_stable_i | input | 1 | High while all involved clocks are stable |
| regblk_reset_o | output | 1 | Register-block reset, active high |
| tx_reset_o | output | 1 | Transmit datapath reset, active high |
| rx_reset_o | output | 1 | Receive datapath reset, active high |
| tx_disable_o | output | 1 | Transmit disable (control bit 0) |
| rx_disable_o | output | 1 | Receive disable (control bit 0) |
| tx_stats_clr_o | output | 1 | One-cycle transmit statistics clear |
| rx_stats_clr_o | output | 1 | One-cycle receive statistics clear |
| tx_done_o | output | 1 | One-cycle transmit sequence done |
| rx_done_o | output | 1 | One-cycle receive sequence done |
| tx_timeout_o | output | 1 | Sticky transmit drain timeout |
| rx_timeout_o | output | 1 | Sticky receive drain timeout |

## Verification
Two functions can meet in one clock edge: a path sequencer releasing its own reset, and the register-block sequencer accepting a new request. The bench raises `regblk_req_i` so that it is sampled at exactly the edge where the transmit minimum width expires. The transmit reset output must then stay high for the whole register-block hold. The statistics-clear pulse must come a full settle count after the output really falls, not after the sequencer's own release.

// File: rtl/mac_rst_pkg.sv
package mac_rst_pkg;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_DISABLE,
        PS_DRAIN,
        PS_ASSERT,
        PS_SETTLE,
        PS_CLEAR,
        PS_ENABLE
    } path_state_e;

    typedef struct packed {
        logic dis;
        logic rst;
        logic stats_clr;
        logic done;
    } path_out_t;

    localparam int NUM_PATHS = 2;
    localparam int PATH_TX   = 0;
    localparam int PATH_RX   = 1;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic path_out_t out_of(input path_state_e s);
        path_out_t o;
        o.dis       = (s != PS_IDLE) && (s != PS_ENABLE);
        o.rst       = (s == PS_ASSERT);
        o.stats_clr = (s == PS_CLEAR);
        o.done      = (s == PS_ENABLE);
        return o;
    endfunction

endpackage

// File: rtl/mac_path_seq.sv
module mac_path_seq
    import mac_rst_pkg::*;
#(
    parameter int MIN_RST = 3,
    parameter int TIMEOUT = 32,
    parameter int SETTLE  = 79,
    parameter int CNT_W   = 7
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      req_i,
    input  logic      busy_i,
    input  logic      clk_stable_i,
    input  logic      ext_hold_i,
    output path_out_t o,
    output logic      timeout_o
);

    localparam logic [CNT_W-1:0] DRAIN_LAST  = CNT_W'(TIMEOUT - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST   = CNT_W'(MIN_RST - 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE - 1);

    path_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             to_q, to_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        to_d    = to_q;
        unique case (state_q)
            PS_IDLE: begin
                cnt_d = '0;
                if (req_i) state_d = PS_DISABLE;
            end
            PS_DISABLE: begin
                cnt_d   = '0;
                state_d = PS_DRAIN;
            end
            PS_DRAIN: begin
                if (!busy_i) begin
                    state_d = PS_ASSERT;
                    cnt_d   = '0;
                end else if (cnt_q == DRAIN_LAST) begin
                    state_d = PS_ASSERT;
                    cnt_d   = '0;
                    to_d    = 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            PS_ASSERT: begin
                if (cnt_q >= HOLD_LAST && clk_stable_i && !ext_hold_i) begin
                    state_d = PS_SETTLE;
                    cnt_d   = '0;
                end else if (cnt_q < HOLD_LAST) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            PS_SETTLE: begin
                if (ext_hold_i) begin
                    cnt_d = '0;
                end else if (cnt_q == SETTLE_LAST) begin
                    state_d = PS_CLEAR;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            PS_CLEAR:  state_d = PS_ENABLE;
            PS_ENABLE: state_d = PS_IDLE;
            default:   state_d = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_IDLE;
            cnt_q   <= '0;
            to_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            to_q    <= to_d;
        end
    end

    assign o         = out_of(state_q);
    assign timeout_o = to_q;

endmodule

// File: rtl/mac_regblk_seq.sv
module mac_regblk_seq #(
    parameter int MIN_RST = 3,
    parameter int CNT_W   = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    input  logic clk_stable_i,
    output logic hold_o
);

    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(MIN_RST - 1);

    logic             hold_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!hold_q) begin
            cnt_q <= '0;
            if (req_i) hold_q <= 1'b1;
        end else begin
            if (cnt_q >= HOLD_LAST && clk_stable_i && !req_i) begin
                hold_q <= 1'b0;
                cnt_q  <= '0;
            end else if (cnt_q < HOLD_LAST) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign hold_o = hold_q;

endmodule

// File: rtl/mac_path_rst_seq.sv
module mac_path_rst_seq
    import mac_rst_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 6400,
    parameter int SETTLE_NS     = 500,
    parameter int MIN_RST_CYC   = 3,
    parameter int DRAIN_TIMEOUT = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic regblk_req_i,
    input  logic tx_req_i,
    input  logic rx_req_i,
    input  logic tx_busy_i,
    input  logic rx_busy_i,
    input  logic clk_stable_i,
    output logic regblk_reset_o,
    output logic tx_reset_o,
    output logic rx_reset_o,
    output logic tx_disable_o,
    output logic rx_disable_o,
    output logic tx_stats_clr_o,
    output logic rx_stats_clr_o,
    output logic tx_done_o,
    output logic rx_done_o,
    output logic tx_timeout_o,
    output logic rx_timeout_o
);

    localparam int SETTLE_CYC = ceil_div(SETTLE_NS * 1000, CLK_PERIOD_PS);
    localparam int CNT_TOP    = max3(DRAIN_TIMEOUT, SETTLE_CYC, MIN_RST_CYC);
    localparam int CNT_W      = $clog2(CNT_TOP + 1);
    localparam int RB_CNT_W   = $clog2(MIN_RST_CYC + 1);

    logic [NUM_PATHS-1:0] req_v, busy_v, seq_rst, dis_v, stats_v, done_v, tmo_v;
    logic                 rb_hold;
    path_out_t            pout [NUM_PATHS];

    assign req_v[PATH_TX]  = tx_req_i;
    assign req_v[PATH_RX]  = rx_req_i;
    assign busy_v[PATH_TX] = tx_busy_i;
    assign busy_v[PATH_RX] = rx_busy_i;

    mac_regblk_seq #(
        .MIN_RST (MIN_RST_CYC),
        .CNT_W   (RB_CNT_W)
    ) u_regblk (
        .clk          (clk),
        .rst          (rst),
        .req_i        (regblk_req_i),
        .clk_stable_i (clk_stable_i),
        .hold_o       (rb_hold)
    );

    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
        mac_path_seq #(
            .MIN_RST (MIN_RST_CYC),
            .TIMEOUT (DRAIN_TIMEOUT),
            .SETTLE  (SETTLE_CYC),
            .CNT_W   (CNT_W)
        ) u_seq (
            .clk          (clk),
            .rst          (rst),
            .req_i        (req_v[p]),
            .busy_i       (busy_v[p]),
            .clk_stable_i (clk_stable_i),
            .ext_hold_i   (rb_hold),
            .o            (pout[p]),
            .timeout_o    (tmo_v[p])
        );
        assign seq_rst[p] = pout[p].rst;
        assign dis_v[p]   = pout[p].dis;
        assign stats_v[p] = pout[p].stats_clr;
        assign done_v[p]  = pout[p].done;
    end

    assign regblk_reset_o = rb_hold;
    assign tx_reset_o     = seq_rst[PATH_TX] | rb_hold;
    assign rx_reset_o     = seq_rst[PATH_RX] | rb_hold;
    assign tx_disable_o   = dis_v[PATH_TX];
    assign rx_disable_o   = dis_v[PATH_RX];
    assign tx_stats_clr_o = stats_v[PATH_TX];
    assign rx_stats_clr_o = stats_v[PATH_RX];
    assign tx_done_o      = done_v[PATH_TX];
    assign rx_done_o      = done_v[PATH_RX];
    assign tx_timeout_o   = tmo_v[PATH_TX];
    assign rx_timeout_o   = tmo_v[PATH_RX];

endmodule

// File: rtl/mac_path_rst_seq_chk.sv
module mac_path_rst_seq_chk #(
    parameter int MIN_RST = 3
) (
    input logic       clk,
    input logic       rst,
    input logic       clk_stable_i,
    input logic       regblk_reset_o,
    input logic       tx_reset_o,
    input logic       rx_reset_o,
    input logic [1:0] seq_rst,
    input logic [1:0] dis_v,
    input logic [1:0] stats_v,
    input logic [1:0] done_v,
    input logic [1:0] tmo_v,
    input logic [1:0] busy_v
);

    logic [2:0] outs;
    logic [7:0] run [3];

    assign outs = {regblk_reset_o, rx_reset_o, tx_reset_o};

    for (genvar i = 0; i < 3; i++) begin : g_run
        always_ff @(posedge clk) begin
            if (rst)                 run[i] <= '0;
            else if (!outs[i])       run[i] <= '0;
            else if (run[i] != 8'hFF) run[i] <= run[i] + 8'd1;
        end

        p_min_width_r2: assert property (@(posedge clk) disable iff (rst)
            $fell(outs[i]) |-> (run[i] >= 8'(MIN_RST)));
    end

    p_regblk_covers_r1: assert property (@(posedge clk) disable iff (rst)
        regblk_reset_o |-> (tx_reset_o && rx_reset_o));

    p_tx_after_regblk_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_reset_o) |-> !regblk_reset_o);

    p_rx_after_regblk_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_reset_o) |-> !regblk_reset_o);

    p_regblk_stable_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(regblk_reset_o) |-> $past(clk_stable_i));

    for (genvar p = 0; p < 2; p++) begin : g_path
        p_disabled_in_reset_r4: assert property (@(posedge clk) disable iff (rst)
            seq_rst[p] |-> dis_v[p]);

        p_drained_r5: assert property (@(posedge clk) disable iff (rst)
            $rose(seq_rst[p]) |-> (!$past(busy_v[p]) || tmo_v[p]));

        p_timeout_sticky_r6: assert property (@(posedge clk) disable iff (rst)
            tmo_v[p] |=> tmo_v[p]);

        p_release_stable_r7: assert property (@(posedge clk) disable iff (rst)
            $fell(seq_rst[p]) |-> $past(clk_stable_i));

        p_clear_then_done_r9: assert property (@(posedge clk) disable iff (rst)
            stats_v[p] |=> (done_v[p] && !stats_v[p] && !dis_v[p]));
    end

endmodule

bind mac_path_rst_seq mac_path_rst_seq_chk #(.MIN_RST(MIN_RST_CYC)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .clk_stable_i   (clk_stable_i),
    .regblk_reset_o (regblk_reset_o),
    .tx_reset_o     (tx_reset_o),
    .rx_reset_o     (rx_reset_o),
    .seq_rst        (seq_rst),
    .dis_v          (dis_v),
    .stats_v        (stats_v),
    .done_v         (done_v),
    .tmo_v          (tmo_v),
    .busy_v         (busy_v)
);

// File: tb/mac_path_rst_seq_tb_top.sv
module mac_path_rst_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int MIN        = 3;
    localparam int TO         = 32;
    localparam int PER_PS     = 6400;
    localparam int SET_NS     = 500;
    localparam int S          = (SET_NS * 1000 + PER_PS - 1) / PER_PS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic regblk_req = 1'b0, tx_req = 1'b0, rx_req = 1'b0;
    logic tx_busy = 1'b0, rx_busy = 1'b0, clk_stable = 1'b1;
    logic regblk_reset, tx_reset, rx_reset, tx_dis, rx_dis;
    logic tx_clr, rx_clr, tx_done, rx_done, tx_to, rx_to;

    logic [1:0] rst_v, dis_v, clr_v, done_v, to_v;
    assign rst_v  = {rx_reset, tx_reset};
    assign dis_v  = {rx_dis, tx_dis};
    assign clr_v  = {rx_clr, tx_clr};
    assign done_v = {rx_done, tx_done};
    assign to_v   = {rx_to, tx_to};

    always #(CLK_PERIOD / 2) clk = ~clk;

    mac_path_rst_seq #(
        .CLK_PERIOD_PS (PER_PS),
        .SETTLE_NS     (SET_NS),
        .MIN_RST_CYC   (MIN),
        .DRAIN_TIMEOUT (TO)
    ) dut_i (
        .clk            (clk),
        .rst            (rst),
        .regblk_req_i   (regblk_req),
        .tx_req_i       (tx_req),
        .rx_req_i       (rx_req),
        .tx_busy_i      (tx_busy),
        .rx_busy_i      (rx_busy),
        .clk_stable_i   (clk_stable),
        .regblk_reset_o (regblk_reset),
        .tx_reset_o     (tx_reset),
        .rx_reset_o     (rx_reset),
        .tx_disable_o   (tx_dis),
        .rx_disable_o   (rx_dis),
        .tx_stats_clr_o (tx_clr),
        .rx_stats_clr_o (rx_clr),
        .tx_done_o      (tx_done),
        .rx_done_o      (rx_done),
        .tx_timeout_o   (tx_to),
        .rx_timeout_o   (rx_to)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit exp_to [2] = '{1'b0, 1'b0};

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // R5/R6: cycle (after request sample) where the path reset is first seen high
    function automatic int exp_assert(input int j);
        if (j > TO) return TO + 1;
        return ((j > 1) ? j : 1) + 1;
    endfunction

    // R2/R7/R8: cycle where the path reset output is first seen low
    function automatic int exp_release(input int a, input bit coin, input int stable_at);
        if (coin) return a + 2 * MIN;
        if (stable_at >= 0 && stable_at + 1 > a + MIN) return stable_at + 1;
        return a + MIN;
    endfunction

    // mask: paths; j: busy drops after cycle j; spam: extra requests (R10);
    // coin: register-block request hits the path release edge (R8/R1); stable_at: stable raised at cycle
    task automatic run_seq(input bit [1:0] mask, input int j, input bit spam,
                           input bit coin, input int stable_at);
        int a  = exp_assert(j);
        int r  = exp_release(a, coin, stable_at);
        int st = r + S;
        int dn = st + 1;
        int a_obs [2], r_obs [2], st_obs [2], dn_obs [2], st_cnt [2], dn_cnt [2];
        int dis0 [2], dis_dn [2], dis_end [2];
        int rb_at = -1;
        for (int p = 0; p < 2; p++) begin
            a_obs[p] = -1; r_obs[p] = -1; st_obs[p] = -1; dn_obs[p] = -1;
            st_cnt[p] = 0; dn_cnt[p] = 0; dis0[p] = -1; dis_dn[p] = -1; dis_end[p] = -1;
        end
        @(negedge clk);
        tx_busy = mask[0] && (j > 0);
        rx_busy = mask[1] && (j > 0);
        if (stable_at >= 0) clk_stable = 1'b0;
        tx_req = mask[0];
        rx_req = mask[1];
        for (int k = 0; k <= dn + 3; k++) begin
            @(negedge clk);
            for (int p = 0; p < 2; p++) begin
                if (k == 0) dis0[p] = int'(dis_v[p]);
                if (rst_v[p] && a_obs[p] < 0) a_obs[p] = k;
                if (!rst_v[p] && a_obs[p] >= 0 && r_obs[p] < 0) r_obs[p] = k;
                if (clr_v[p]) begin st_cnt[p]++; if (st_obs[p] < 0) st_obs[p] = k; end
                if (done_v[p]) begin dn_cnt[p]++; if (dn_obs[p] < 0) dn_obs[p] = k; end
                if (k == dn) dis_dn[p] = int'(dis_v[p]);
                if (k == dn + 3) dis_end[p] = int'(dis_v[p]);
            end
            if (coin && k == a + MIN) rb_at = int'(regblk_reset);
            tx_req = mask[0] && spam && (k < dn - 1) && ($urandom_range(0, 1) == 1);
            rx_req = mask[1] && spam && (k < dn - 1) && ($urandom_range(0, 1) == 1);
            if (k >= j) begin tx_busy = 1'b0; rx_busy = 1'b0; end
            if (k == stable_at) clk_stable = 1'b1;
            regblk_req = coin && (k == a + MIN - 1);
        end
        tx_req = 1'b0; rx_req = 1'b0; regblk_req = 1'b0;
        for (int p = 0; p < 2; p++) begin
            if (mask[p]) begin
                exp_to[p] = exp_to[p] | (j > TO);
                chk($sformatf("R4 p%0d disable after request", p), dis0[p], 1);
                chk($sformatf("R5 p%0d reset rise cycle j=%0d", p, j), a_obs[p], a);
                chk($sformatf("R7 p%0d reset fall cycle", p), r_obs[p], r);
                chk($sformatf("R8 p%0d stats clear cycle", p), st_obs[p], st);
                chk($sformatf("R9 p%0d stats clear count", p), st_cnt[p], 1);
                chk($sformatf("R9 p%0d done cycle", p), dn_obs[p], dn);
                chk($sformatf("R10 p%0d done count", p), dn_cnt[p], 1);
                chk($sformatf("R9 p%0d disable low at done", p), dis_dn[p], 0);
                chk($sformatf("R10 p%0d stays enabled after done", p), dis_end[p], 0);
                chk($sformatf("R6 p%0d timeout flag", p), int'(to_v[p]), int'(exp_to[p]));
            end else begin
                chk($sformatf("R11 p%0d untouched", p), st_cnt[p], 0);
            end
        end
        if (coin) chk("R1 regblk held at path release edge", rb_at, 1);
    endtask

    // R1/R2/R7: register-block pulse, stable raised after cycle stable_at (-1: always stable)
    task automatic run_regblk(input int stable_at);
        int rel = (stable_at >= MIN) ? stable_at + 1 : MIN;
        @(negedge clk);
        if (stable_at >= 0) clk_stable = 1'b0;
        regblk_req = 1'b1;
        for (int k = 0; k <= rel; k++) begin
            @(negedge clk);
            regblk_req = 1'b0;
            chk($sformatf("R2 regblk level k=%0d", k), int'(regblk_reset), int'(k < rel));
            chk($sformatf("R1 tx covered k=%0d", k), int'(tx_reset), int'(k < rel));
            chk($sformatf("R1 rx covered k=%0d", k), int'(rx_reset), int'(k < rel));
            if (k == stable_at) clk_stable = 1'b1;
        end
        clk_stable = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog (R9 done never reached): actual 150000 cycles expected fewer");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R12 reset outputs", int'({regblk_reset, rst_v}), 0);
        chk("R12 disable", int'(dis_v), 0);
        chk("R12 pulses", int'({clr_v, done_v}), 0);
        chk("R12 timeout", int'(to_v), 0);

        run_regblk(-1);
        run_regblk(6);
        run_seq(2'b01, 0, 1'b0, 1'b0, -1);
        run_seq(2'b10, TO + 3, 1'b0, 1'b0, -1);
        run_seq(2'b11, 4, 1'b0, 1'b0, -1);
        run_seq(2'b01, 2, 1'b0, 1'b0, exp_assert(2) + MIN + 4);
        run_seq(2'b01, 1, 1'b0, 1'b1, -1);
        run_seq(2'b10, 5, 1'b1, 1'b0, -1);
        run_seq(2'b01, TO, 1'b0, 1'b0, -1);

        for (int it = 0; it < 20; it++) begin
            bit [1:0] m = 2'($urandom_range(1, 3));
            int jj = int'($urandom_range(0, TO + 4));
            bit sp = ($urandom_range(0, 1) == 1);
            bit cn = ($urandom_range(0, 3) == 0);
            run_seq(m, jj, sp, cn, -1);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule